// File: doc/BRIEF.md
# Endian Lane Aligner

The aligner sits between a load/store unit and a 64-bit memory data bus. Each accepted access carries a base address and an offset, whose sum is the effective byte address. It also carries a size code, an access class, a load/store flag, an endian mode bit, a sign-extend flag, up to 16 bytes of store data and up to two bus words of read data. The block is one registered stage. One cycle after acceptance it presents the effective address, a byte-enable mask and the store data moved into the byte lanes that the address and byte order select. For loads it also presents the read bytes, right-justified into a register value. An access that is not legal is not passed on: the block raises a one-cycle trap strobe instead.

Only data-class accesses follow the endian mode bit. Instruction fetches and page-table walks always use little-endian lanes. A 16-byte access leaves the block as two bus beats, lower address first. While the second beat is issued, the block refuses new input for that one cycle.

Top module: `endian_lane_aligner`

## Requirements
- R1: The beat-0 address output equals base plus offset modulo 2^32. The second beat of a 16-byte access carries that address plus 8, also wrapping.
- R2: Size codes 0,1,2,3,4 mean 1,2,4,8,16 bytes. In little-endian order, memory byte at address A lives in lane A mod 8 (bits 8*(A mod 8)+7 down to 8*(A mod 8)). Store value byte i goes to address ea+i. Bit j of the byte enable marks lane j. Lanes outside the access are disabled.
- R3: For a data-class access (class code 0) with the mode bit set, address A lives in lane 7-(A mod 8), and the most significant value byte sits at the lowest address.
- R4: Class codes 1 (fetch) and 2 (table walk) use the little-endian mapping whatever the mode bit is.
- R5: 2-, 4- and 8-byte accesses whose low 1, 2 or 3 address bits are not zero raise the trap strobe for one cycle. They produce no valid beat and all byte enables stay low.
- R6: A 16-byte access whose low 4 address bits are not zero traps in the same way and writes nothing.
- R7: A legal 16-byte access produces beat 0 and then beat 1 on consecutive cycles, both with all eight enables set. Ready is low in the beat-0 cycle, and a request offered then is ignored. In little-endian order beat 0 carries store bits 63:0; in big-endian order it carries bits 127:64.
- R8: A load result is right-justified: value byte i comes from address ea+i (little endian) or from address ea+n-1-i (big endian), with the upper bits zero. For 16-byte loads read word 0 holds ea..ea+7 and word 1 holds ea+8..ea+15. On loads the write-data output is zero.
- R9: With the sign-extend flag set, a load narrower than 16 bytes fills every bit above the value with the value's top bit.
- R10: The mode bit is sampled per access, so back-to-back accesses with different mode bits each use their own mapping.
- R11: Size codes 5 to 7 trap in the same way as a misaligned access.
- R12: After reset, valid and trap are low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_base | input | 32 | Base address |
| in_offset | input | 32 | Address offset |
| in_size | input | 3 | Size code (0..4 = 1,2,4,8,16 bytes) |
| in_class | input | 2 | 0 data, 1 fetch, 2 table walk |
| in_store | input | 1 | 1 store, 0 load |
| in_big | input | 1 | Big-endian mode bit |
| in_sext | input | 1 | Sign-extend load result |
| in_wdata | input | 128 | Store value, right-justified |
| in_rdata | input | 128 | Read words: [63:0] at ea, [127:64] at ea+8 |
| out_valid | output | 1 | Beat present |
| out_beat | output | 1 | Beat index of a 16-byte access |
| out_store | output | 1 | Beat is a store |
| out_addr | output | 32 | Beat byte address |
| out_be | output | 8 | Lane enables |
| out_wdata | output | 64 | Lane-steered store data |
| out_ldata | output | 128 | Right-justified load value |
| out_trap | output | 1 | Data-access trap strobe |

## Verification
Beat 0, the load value and the trap strobe all come out one clock edge after the request is taken. Beat 1 of a 16-byte access comes one edge after that. The bench drives each request on a falling edge and samples the matching result on the falling edge after the next rising edge. It waits one further rising edge before looking at beat 1. Expected lanes, enables and values are built byte by byte from the address mapping rules, independently of the shift arithmetic in the design.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam int ADDR_W  = 32;
  localparam int LANES   = 8;
  localparam int BEAT_W  = LANES * 8;
  localparam int QUAD_W  = 2 * BEAT_W;
  localparam int LANE_SW = $clog2(LANES);

  typedef enum logic [2:0] {
    SZ_1B  = 3'd0,
    SZ_2B  = 3'd1,
    SZ_4B  = 3'd2,
    SZ_8B  = 3'd3,
    SZ_16B = 3'd4
  } acc_size_e;

  typedef enum logic [1:0] {
    CL_DATA  = 2'd0,
    CL_FETCH = 2'd1,
    CL_WALK  = 2'd2
  } acc_class_e;

  // number of bytes moved by a size code, 0 for reserved codes
  function automatic logic [4:0] size_bytes(input logic [2:0] sz);
    case (sz)
      SZ_1B:   return 5'd1;
      SZ_2B:   return 5'd2;
      SZ_4B:   return 5'd4;
      SZ_8B:   return 5'd8;
      SZ_16B:  return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  // natural alignment test on the low address bits
  function automatic logic misaligned(input logic [2:0] sz, input logic [3:0] lo);
    case (sz)
      SZ_2B:   return lo[0];
      SZ_4B:   return |lo[1:0];
      SZ_8B:   return |lo[2:0];
      SZ_16B:  return |lo;
      default: return 1'b0;
    endcase
  endfunction

  // lowest lane of the access; big endian folds the offset as a XOR with (8 - size)
  function automatic logic [LANE_SW-1:0] lane_base(input logic [2:0] sz,
                                                   input logic [LANE_SW-1:0] a,
                                                   input logic big);
    case (sz)
      SZ_1B:   return big ? (a ^ 3'd7) : a;
      SZ_2B:   return big ? (a ^ 3'd6) : a;
      SZ_4B:   return big ? (a ^ 3'd4) : a;
      default: return '0;
    endcase
  endfunction

  // enable pattern of the access before it is shifted to its base lane
  function automatic logic [LANES-1:0] byte_mask(input logic [2:0] sz);
    case (sz)
      SZ_1B:   return 8'h01;
      SZ_2B:   return 8'h03;
      SZ_4B:   return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/aligner_addr_check.sv
module aligner_addr_check
  import lsu_align_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  input  logic [2:0]        size,
  input  logic [1:0]        cls,
  input  logic              big,
  output logic [ADDR_W-1:0] ea,
  output logic              big_eff,
  output logic              bad_size,
  output logic              bad_align,
  output logic              trap,
  output logic              is_quad
);

  always_comb begin
    ea        = base + offset;
    big_eff   = big && (cls == CL_DATA);
    bad_size  = (size > SZ_16B);
    bad_align = misaligned(size, ea[3:0]);
    trap      = bad_size || bad_align;
    is_quad   = (size == SZ_16B);
  end

endmodule

// File: rtl/aligner_lane_steer.sv
module aligner_lane_steer
  import lsu_align_pkg::*;
(
  input  logic [2:0]         size,
  input  logic [LANE_SW-1:0] base_lane,
  input  logic [BEAT_W-1:0]  value,
  output logic [LANES-1:0]   be,
  output logic [BEAT_W-1:0]  data
);

  logic [BEAT_W-1:0] keep;

  always_comb begin
    be = byte_mask(size) << base_lane;
    for (int k = 0; k < LANES; k++) begin
      keep[k*8 +: 8] = {8{byte_mask(size)[k]}};
    end
    data = (value & keep) << {base_lane, 3'b000};
  end

endmodule

// File: rtl/aligner_load_extract.sv
module aligner_load_extract
  import lsu_align_pkg::*;
(
  input  logic [2:0]         size,
  input  logic [LANE_SW-1:0] base_lane,
  input  logic               big,
  input  logic               sext,
  input  logic [QUAD_W-1:0]  rdata,
  output logic [QUAD_W-1:0]  value
);

  logic [BEAT_W-1:0] shifted;
  logic [4:0]        nb;
  logic              sign;
  logic [7:0]        fill;

  always_comb begin
    shifted = rdata[BEAT_W-1:0] >> {base_lane, 3'b000};
    nb      = size_bytes(size);
    case (size)
      SZ_1B:   sign = shifted[7];
      SZ_2B:   sign = shifted[15];
      SZ_4B:   sign = shifted[31];
      default: sign = shifted[63];
    endcase
    fill = (sext && sign) ? 8'hFF : 8'h00;
    for (int k = 0; k < 2 * LANES; k++) begin
      if (k < LANES) value[k*8 +: 8] = (5'(k) < nb) ? shifted[k*8 +: 8] : fill;
      else           value[k*8 +: 8] = fill;
    end
    if (size == SZ_16B) begin
      value = big ? {rdata[BEAT_W-1:0], rdata[QUAD_W-1:BEAT_W]} : rdata;
    end
  end

endmodule

// File: rtl/endian_lane_aligner.sv
module endian_lane_aligner
  import lsu_align_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_offset,
  input  logic [2:0]        in_size,
  input  logic [1:0]        in_class,
  input  logic              in_store,
  input  logic              in_big,
  input  logic              in_sext,
  input  logic [QUAD_W-1:0] in_wdata,
  input  logic [QUAD_W-1:0] in_rdata,
  output logic              out_valid,
  output logic              out_beat,
  output logic              out_store,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_be,
  output logic [BEAT_W-1:0] out_wdata,
  output logic [QUAD_W-1:0] out_ldata,
  output logic              out_trap
);

  // named internal events
  logic              accept;
  logic [ADDR_W-1:0] ea_c;
  logic              big_c, bad_size_c, bad_align_c, trap_c, quad_c;
  logic [LANE_SW-1:0] lane_c;
  logic [LANES-1:0]  be_c;
  logic [BEAT_W-1:0] steer_c;
  logic [QUAD_W-1:0] ld_c;
  logic [BEAT_W-1:0] q_first_c, q_second_c;

  logic              pend_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [BEAT_W-1:0] hold_wdata_q;

  assign in_ready = !pend_q;
  assign accept   = in_valid && in_ready;

  aligner_addr_check u_addr (
    .base      (in_base),
    .offset    (in_offset),
    .size      (in_size),
    .cls       (in_class),
    .big       (in_big),
    .ea        (ea_c),
    .big_eff   (big_c),
    .bad_size  (bad_size_c),
    .bad_align (bad_align_c),
    .trap      (trap_c),
    .is_quad   (quad_c)
  );

  assign lane_c = lane_base(in_size, ea_c[LANE_SW-1:0], big_c);

  aligner_lane_steer u_steer (
    .size      (in_size),
    .base_lane (lane_c),
    .value     (in_wdata[BEAT_W-1:0]),
    .be        (be_c),
    .data      (steer_c)
  );

  aligner_load_extract u_load (
    .size      (in_size),
    .base_lane (lane_c),
    .big       (big_c),
    .sext      (in_sext),
    .rdata     (in_rdata),
    .value     (ld_c)
  );

  // the lowest address of a 16-byte value holds its most significant half in big endian
  assign q_first_c  = big_c ? in_wdata[QUAD_W-1:BEAT_W] : in_wdata[BEAT_W-1:0];
  assign q_second_c = big_c ? in_wdata[BEAT_W-1:0] : in_wdata[QUAD_W-1:BEAT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_beat     <= 1'b0;
      out_store    <= 1'b0;
      out_addr     <= '0;
      out_be       <= '0;
      out_wdata    <= '0;
      out_ldata    <= '0;
      out_trap     <= 1'b0;
      pend_q       <= 1'b0;
      hold_addr_q  <= '0;
      hold_wdata_q <= '0;
    end else begin
      out_trap <= accept && trap_c;
      if (pend_q) begin
        out_valid <= 1'b1;
        out_beat  <= 1'b1;
        out_addr  <= hold_addr_q;
        out_be    <= '1;
        out_wdata <= hold_wdata_q;
        pend_q    <= 1'b0;
      end else if (accept && !trap_c) begin
        out_valid    <= 1'b1;
        out_beat     <= 1'b0;
        out_store    <= in_store;
        out_addr     <= ea_c;
        out_be       <= be_c;
        out_wdata    <= in_store ? (quad_c ? q_first_c : steer_c) : '0;
        out_ldata    <= in_store ? '0 : ld_c;
        pend_q       <= quad_c;
        hold_addr_q  <= ea_c + ADDR_W'(LANES);
        hold_wdata_q <= in_store ? q_second_c : '0;
      end else begin
        out_valid <= 1'b0;
        out_beat  <= 1'b0;
        out_be    <= '0;
        out_wdata <= '0;
      end
    end
  end

  // R5 R6: a taken misaligned request yields the strobe and no beat
  p_trap_blocks_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && bad_align_c |=> out_trap && !out_valid);

  // R11: reserved size codes trap
  p_reserved_size_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && bad_size_c |=> out_trap && out_be == '0);

  // R6: trap strobe never coincides with a beat
  p_trap_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_trap |-> !out_valid);

  // R7: a legal 16-byte request closes input for one cycle, then issues beat 1
  p_quad_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && quad_c && !trap_c |=> !in_ready && out_valid && !out_beat);
  p_quad_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> out_valid && out_beat && out_be == '1 && in_ready);

  // R2: idle cycles drive no enables; a narrow beat enables exactly its size in lanes
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_be == '0);
  p_enable_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !trap_c && !quad_c |=> $countones(out_be) == int'($past(size_bytes(in_size))));

endmodule

// File: tb/endian_lane_aligner_tb_top.sv
module endian_lane_aligner_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_base = '0, in_offset = '0;
  logic [2:0]   in_size = '0;
  logic [1:0]   in_class = '0;
  logic         in_store = 1'b0, in_big = 1'b0, in_sext = 1'b0;
  logic [127:0] in_wdata = '0, in_rdata = '0;
  logic         out_valid, out_beat, out_store, out_trap;
  logic [31:0]  out_addr;
  logic [7:0]   out_be;
  logic [63:0]  out_wdata;
  logic [127:0] out_ldata;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  endian_lane_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_offset(in_offset), .in_size(in_size),
    .in_class(in_class), .in_store(in_store), .in_big(in_big),
    .in_sext(in_sext), .in_wdata(in_wdata), .in_rdata(in_rdata),
    .out_valid(out_valid), .out_beat(out_beat), .out_store(out_store),
    .out_addr(out_addr), .out_be(out_be), .out_wdata(out_wdata),
    .out_ldata(out_ldata), .out_trap(out_trap)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ea, input int sz, input int cls,
                       input int st, input int bg, input int sx,
                       input logic [127:0] wv, input logic [127:0] rv);
    logic [31:0] b;
    b = $urandom();
    in_valid  = 1'b1;
    in_base   = b;
    in_offset = ea - b;
    in_size   = 3'(sz);
    in_class  = 2'(cls);
    in_store  = st[0];
    in_big    = bg[0];
    in_sext   = sx[0];
    in_wdata  = wv;
    in_rdata  = rv;
  endtask

  // one access, checked beat by beat from the byte mapping rules
  task automatic access(input logic [31:0] ea, input int sz, input int cls,
                        input int st, input int bg, input int sx);
    logic [127:0] wv, rv, exp_ld;
    logic [7:0]   exp_be;
    logic [63:0]  exp_wd;
    int n, beats, lane, vb;
    bit trap, eb;
    string mreq;
    wv = {$urandom(), $urandom(), $urandom(), $urandom()};
    rv = {$urandom(), $urandom(), $urandom(), $urandom()};
    @(negedge clk);
    drive(ea, sz, cls, st, bg, sx, wv, rv);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n    = (sz <= 4) ? (1 << sz) : 0;
    trap = (n == 0) || ((ea & 32'(n - 1)) != 0);
    eb   = (bg != 0) && (cls == 0);
    if (trap) begin
      mreq = (sz > 4) ? "R11" : ((sz == 4) ? "R6" : "R5");
      chk(mreq, "trap", 128'(out_trap), 128'd1);
      chk(mreq, "valid", 128'(out_valid), 128'd0);
      chk(mreq, "be", 128'(out_be), 128'd0);
      return;
    end
    mreq = (cls != 0) ? "R4" : (eb ? "R3" : "R2");
    exp_ld = '0;
    for (int i = 0; i < n; i++) begin
      lane = eb ? 7 - ((ea + 32'(i)) % 8) : (ea + 32'(i)) % 8;
      vb   = eb ? n - 1 - i : i;
      exp_ld[vb*8 +: 8] = rv[(i / 8) * 64 + lane * 8 +: 8];
    end
    if (sx != 0 && n < 16 && exp_ld[8*n-1]) begin
      for (int k = 8 * n; k < 128; k++) exp_ld[k] = 1'b1;
    end
    beats = (n == 16) ? 2 : 1;
    for (int j = 0; j < beats; j++) begin
      exp_be = '0;
      exp_wd = '0;
      for (int i = 0; i < ((n == 16) ? 8 : n); i++) begin
        lane = eb ? 7 - ((ea + 32'(8 * j + i)) % 8) : (ea + 32'(8 * j + i)) % 8;
        vb   = eb ? n - 1 - (8 * j + i) : 8 * j + i;
        exp_be[lane] = 1'b1;
        exp_wd[lane*8 +: 8] = wv[vb*8 +: 8];
      end
      chk("R7", "valid", 128'(out_valid), 128'd1);
      chk("R5", "no trap", 128'(out_trap), 128'd0);
      chk("R7", "beat", 128'(out_beat), 128'(j));
      chk("R1", "addr", 128'(out_addr), 128'(ea + 32'(8 * j)));
      chk(mreq, "be", 128'(out_be), 128'(exp_be));
      chk(mreq, "wdata", 128'(out_wdata), st != 0 ? 128'(exp_wd) : 128'd0);
      if (j == 0 && st == 0) chk((sx != 0) ? "R9" : "R8", "ldata", out_ldata, exp_ld);
      if (n == 16) chk("R7", "ready", 128'(in_ready), (j == 0) ? 128'd0 : 128'd1);
      if (j + 1 < beats) begin
        @(posedge clk);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "valid", 128'(out_valid), 128'd0);
    chk("R12", "trap", 128'(out_trap), 128'd0);
    chk("R12", "ready", 128'(in_ready), 128'd1);
    rst_n = 1'b1;

    // sweep of size, low address bits, class, mode, direction, extension
    for (int sz = 0; sz < 8; sz++)
      for (int lo = 0; lo < 16; lo++)
        for (int cls = 0; cls < 3; cls++)
          for (int bg = 0; bg < 2; bg++)
            for (int st = 0; st < 2; st++)
              for (int sx = 0; sx < 2; sx++)
                access({$urandom() & 32'hFFFF_FFF0} | 32'(lo), sz, cls, st, bg, sx);

    // R1: the sum wraps past the top of the address space
    @(negedge clk);
    drive(32'h0, 0, 0, 1, 0, 0, 128'h5A, '0);
    in_base = 32'hFFFF_FFF8;
    in_offset = 32'h0000_000B;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "wrap addr", 128'(out_addr), 128'h3);
    chk("R1", "wrap be", 128'(out_be), 128'h08);

    // R10: mode bit flips between back-to-back word stores
    @(negedge clk);
    drive(32'h40, 2, 0, 1, 1, 0, 128'h1122_3344, '0);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "big be", 128'(out_be), 128'hF0);
    chk("R10", "big data", 128'(out_wdata), 128'h1122_3344_0000_0000);
    drive(32'h40, 2, 0, 1, 0, 0, 128'h1122_3344, '0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "little be", 128'(out_be), 128'h0F);
    chk("R10", "little data", 128'(out_wdata), 128'h1122_3344);

    // R7: a request offered while beat 1 is pending is dropped
    @(negedge clk);
    drive(32'h100, 4, 0, 1, 0, 0, {64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444}, '0);
    @(posedge clk);
    @(negedge clk);
    chk("R7", "busy ready", 128'(in_ready), 128'd0);
    chk("R7", "beat0 data", 128'(out_wdata), 128'h1111_2222_3333_4444);
    drive(32'h200, 0, 0, 1, 0, 0, 128'h77, '0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "beat1 addr", 128'(out_addr), 128'h108);
    chk("R7", "beat1 data", 128'(out_wdata), 128'hAAAA_BBBB_CCCC_DDDD);
    @(posedge clk);
    @(negedge clk);
    chk("R7", "dropped req", 128'(out_valid), 128'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule